// File: doc/BRIEF.md
# Nibble-Serialized Result Calculator

This block is a 16-bit arithmetic and logic calculator whose result never leaves as a full word. Two 16-bit operands and a 3-bit operation code feed a combinational kernel that adds, subtracts (two's complement) or applies a bitwise boolean function. A load strobe captures the kernel's 16-bit result into four 4-bit registers, one per nibble, all on the same rising clock edge. The registers then hold that result until the next load or a synchronous reset.

A single 4-bit bus leaves the block. Each nibble register feeds its own output stage, and at most one stage is enabled at a time. A 2-bit nibble select picks the stage, and an output enable gates all of them. The tri-state behaviour is modelled as a one-hot-selected OR of the stages, so a disabled bus reads zero. The per-stage enables also appear on a port, so the surrounding logic can see which stage is driving.

The load strobe is a plain control pin. It needs no ready signal because the block accepts a new operation on every cycle and never applies back-pressure. The nibble bus reads combinationally from the stored registers, so a new select value shows in the same cycle.

Top module: `nibble_calc`

## Requirements
- R1: After a synchronous reset, all four nibble registers hold zero, so every select value reads 0000 on the bus while the output enable is high.
- R2: Opcode 000 stores opa + opb modulo 2^16, dropping the carry out of bit 15.
- R3: Opcode 001 stores opa - opb in two's complement modulo 2^16 (1 - 2 gives 0xFFFF).
- R4: Opcode 010 stores opa AND opb, opcode 011 stores opa OR opb, and opcode 100 stores opa XOR opb.
- R5: Opcode 101 stores the bitwise inverse of opa and ignores opb.
- R6: Opcodes 110 and 111 store zero.
- R7: The registers capture on a rising clock edge only while load is high. With load low, changes to opa, opb or opc leave the stored result unchanged.
- R8: With oen high, nsel 00 puts bits 3:0 of the stored result on nib_bus, 01 puts bits 7:4, 10 puts bits 11:8 and 11 puts bits 15:12.
- R9: With oen low, nib_bus reads 0000 and drv_en reads 0000, whatever nsel is.
- R10: drv_en never has more than one bit set. With oen high, bit nsel of drv_en is the only bit set.
- R11: Reset takes priority over load: if both are high on the same edge, the registers clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture the kernel result on this edge |
| opc | input | 3 | Operation code |
| opa | input | 16 | Operand X |
| opb | input | 16 | Operand Y |
| nsel | input | 2 | Nibble select for the output bus |
| oen | input | 1 | Output enable for the bus |
| nib_bus | output | 4 | Shared nibble output bus |
| drv_en | output | 4 | One-hot enables of the four output stages |

## Verification
A wrong register state shows on nib_bus as soon as the affected nibble is selected, in the cycle after the faulty load, so each check reads all four nibbles back after every load. A hold fault only shows after several idle edges with changing operands, so the bench changes the operands during those edges before it reads back. Select decoding faults appear in the same cycle on drv_en and nib_bus, and the bench sweeps every select value with the enable both high and low.

// File: rtl/nibble_calc_pkg.sv
package nibble_calc_pkg;
  typedef enum logic [2:0] {
    OPC_ADD  = 3'b000,
    OPC_SUB  = 3'b001,
    OPC_AND  = 3'b010,
    OPC_OR   = 3'b011,
    OPC_XOR  = 3'b100,
    OPC_NOTA = 3'b101,
    OPC_RSV6 = 3'b110,
    OPC_RSV7 = 3'b111
  } opc_e;
endpackage

// File: rtl/nc_kernel.sv
module nc_kernel
  import nibble_calc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   opc,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  opc_e op;
  assign op = opc_e'(opc);

  logic [W-1:0] sum;
  logic [W-1:0] dif;
  assign sum = opa + opb;
  assign dif = opa + (~opb) + W'(1);

  always_comb begin
    unique case (op)
      OPC_ADD:  res = sum;
      OPC_SUB:  res = dif;
      OPC_AND:  res = opa & opb;
      OPC_OR:   res = opa | opb;
      OPC_XOR:  res = opa ^ opb;
      OPC_NOTA: res = ~opa;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/nc_nibble_bank.sv
module nc_nibble_bank #(
  parameter int W   = 16,
  parameter int NIB = 4,
  localparam int NUM = W / NIB
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [W-1:0]             din,
  output logic [NUM-1:0][NIB-1:0]  nibs
);
  for (genvar g = 0; g < NUM; g++) begin : g_nib
    always_ff @(posedge clk) begin
      if (rst)
        nibs[g] <= '0;
      else if (load)
        nibs[g] <= din[g*NIB +: NIB];
    end
  end

  // R7: no capture without load
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(nibs));

  // R1 / R11: reset clears every nibble, load or not
  a_r11_reset_wins: assert property (@(posedge clk)
    rst |=> (nibs == '0));
endmodule

// File: rtl/nc_bus_select.sv
module nc_bus_select #(
  parameter int NIB = 4,
  parameter int NUM = 4,
  localparam int SELW = $clog2(NUM)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM-1:0][NIB-1:0]  nibs,
  input  logic [SELW-1:0]          nsel,
  input  logic                     oen,
  output logic [NIB-1:0]           bus,
  output logic [NUM-1:0]           en
);
  for (genvar g = 0; g < NUM; g++) begin : g_stage
    assign en[g] = oen && (nsel == SELW'(g));
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NUM; i++)
      if (en[i]) bus = bus | nibs[i];
  end

  // R10: never two stages on the bus
  a_r10_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en));

  // R9: disabled bus is idle
  a_r9_bus_idle: assert property (@(posedge clk) disable iff (rst)
    !oen |-> (bus == '0 && en == '0));

  // R10: enabled bus has exactly one stage on
  a_r10_one_on: assert property (@(posedge clk) disable iff (rst)
    oen |-> ($countones(en) == 1));
endmodule

// File: rtl/nibble_calc.sv
module nibble_calc
  import nibble_calc_pkg::*;
#(
  parameter int W   = 16,
  parameter int NIB = 4,
  localparam int NUM  = W / NIB,
  localparam int SELW = $clog2(NUM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [2:0]      opc,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [SELW-1:0] nsel,
  input  logic            oen,
  output logic [NIB-1:0]  nib_bus,
  output logic [NUM-1:0]  drv_en
);
  logic [W-1:0]              res;
  logic [NUM-1:0][NIB-1:0]   nibs;
  logic [W-1:0]              word;

  nc_kernel #(.W(W)) u_kernel (
    .opc (opc),
    .opa (opa),
    .opb (opb),
    .res (res)
  );

  nc_nibble_bank #(.W(W), .NIB(NIB)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (res),
    .nibs (nibs)
  );

  nc_bus_select #(.NIB(NIB), .NUM(NUM)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .nibs (nibs),
    .nsel (nsel),
    .oen  (oen),
    .bus  (nib_bus),
    .en   (drv_en)
  );

  assign word = nibs;

  // R2: stored sum wraps modulo 2^W
  a_r2_add: assert property (@(posedge clk) disable iff (rst)
    (load && opc == OPC_ADD) |=> (word == W'($past(opa) + $past(opb))));

  // R3: stored difference in two's complement
  a_r3_sub: assert property (@(posedge clk) disable iff (rst)
    (load && opc == OPC_SUB) |=> (word == W'($past(opa) - $past(opb))));

  // R5: inverse of X
  a_r5_nota: assert property (@(posedge clk) disable iff (rst)
    (load && opc == OPC_NOTA) |=> (word == ~$past(opa)));

  // R6: reserved codes give zero
  a_r6_reserved: assert property (@(posedge clk) disable iff (rst)
    (load && opc[2:1] == 2'b11) |=> (word == '0));
endmodule

// File: tb/test_nibble_calc.sv
module test_nibble_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [2:0]  opc = 3'b000;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic [1:0]  nsel = 2'b00;
  logic        oen = 1'b0;
  logic [3:0]  nib_bus;
  logic [3:0]  drv_en;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nibble_calc i_nibble_calc (
    .clk(clk), .rst(rst), .load(load), .opc(opc), .opa(opa), .opb(opb),
    .nsel(nsel), .oen(oen), .nib_bus(nib_bus), .drv_en(drv_en)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [2:0] c, input logic [15:0] a, input logic [15:0] b);
    case (c)
      3'b000: return a + b;
      3'b001: return a - b;
      3'b010: return a & b;
      3'b011: return a | b;
      3'b100: return a ^ b;
      3'b101: return ~a;
      default: return 16'h0000;
    endcase
  endfunction

  // Read all four nibbles through the bus (R8) and check the enables (R10)
  task automatic read_word(input string tag, input logic [15:0] exp);
    logic [15:0] got;
    oen = 1'b1;
    for (int s = 0; s < 4; s++) begin
      nsel = 2'(s);
      #1;
      got[s*4 +: 4] = nib_bus;
      check("R10 drv_en", {12'h0, drv_en}, 16'(4'b0001 << s));
    end
    check(tag, got, exp);
  endtask

  task automatic do_load(input logic [2:0] c, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opc = c; opa = a; opb = b; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic op_test(input string tag, input logic [2:0] c, input logic [15:0] a, input logic [15:0] b);
    do_load(c, a, b);
    read_word(tag, model(c, a, b));
  endtask

  task automatic t_reset;
    read_word("R1 reset value", 16'h0000);
  endtask

  task automatic t_add;
    op_test("R2 add", 3'b000, 16'h1234, 16'h1111);
    op_test("R2 add wrap", 3'b000, 16'hFFFF, 16'h0002);
    check("R2 wrap value", model(3'b000, 16'hFFFF, 16'h0002), 16'h0001);
  endtask

  task automatic t_sub;
    op_test("R3 sub", 3'b001, 16'd17, 16'd8);
    op_test("R3 sub negative", 3'b001, 16'd1, 16'd2);
    check("R3 neg value", model(3'b001, 16'd1, 16'd2), 16'hFFFF);
  endtask

  task automatic t_logic;
    op_test("R4 and", 3'b010, 16'hF0F0, 16'h3C3C);
    op_test("R4 or",  3'b011, 16'hF0F0, 16'h3C3C);
    op_test("R4 xor", 3'b100, 16'hF0F0, 16'h3C3C);
  endtask

  task automatic t_not;
    op_test("R5 not x", 3'b101, 16'h1234, 16'hFFFF);
  endtask

  task automatic t_reserved;
    do_load(3'b000, 16'h5555, 16'h1111);
    op_test("R6 code 110", 3'b110, 16'hAAAA, 16'h5555);
    do_load(3'b000, 16'h5555, 16'h1111);
    op_test("R6 code 111", 3'b111, 16'hAAAA, 16'h5555);
  endtask

  task automatic t_hold;
    do_load(3'b000, 16'h0F00, 16'h00A5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opc = 3'(k + 2); opa = 16'h9999 + 16'(k); opb = 16'h7777;
    end
    @(negedge clk);
    read_word("R7 hold without load", 16'h0FA5);
  endtask

  task automatic t_select;
    do_load(3'b011, 16'hDC00, 16'h00BA);
    oen = 1'b1;
    for (int s = 0; s < 4; s++) begin
      nsel = 2'(s);
      #1;
      check("R8 nibble position", {12'h0, nib_bus}, 16'(4'hA + s));
    end
  endtask

  task automatic t_disable;
    oen = 1'b0;
    for (int s = 0; s < 4; s++) begin
      nsel = 2'(s);
      #1;
      check("R9 bus off", {12'h0, nib_bus}, 16'h0000);
      check("R9 drv_en off", {12'h0, drv_en}, 16'h0000);
    end
  endtask

  task automatic t_reset_priority;
    do_load(3'b000, 16'h1357, 16'h0000);
    @(negedge clk);
    rst = 1'b1; load = 1'b1; opc = 3'b000; opa = 16'hBEEF; opb = 16'h0000;
    @(negedge clk);
    rst = 1'b0; load = 1'b0;
    read_word("R11 reset over load", 16'h0000);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_not();
    t_reserved();
    t_hold();
    t_select();
    t_disable();
    t_reset_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule